// File: doc/BRIEF.md
# Accumulator Instruction Cycle Controller

This block is the multi-cycle control unit of a small single-bus processor built around an accumulator. It holds the program counter, memory address register, memory buffer register, instruction register, accumulator, stack pointer and a program status word. It moves one register transfer per clock through the fetch, indirect, execute and interrupt subcycles. All instructions and data pass through one synchronous single-port memory. A read is requested in one cycle, and its data is valid in the following cycle. The controller spends that second cycle in a dedicated wait state.

The instruction word is 16 bits. Bits 15:13 hold the opcode, bit 12 is the indirect flag, and bits 11:0 hold the address field. The instruction set has five operations: load, store, add, jump-if-zero and return-from-interrupt. There is one level-sensitive interrupt request. When an interrupt is taken, the controller enters supervisor mode, pushes the return address onto a downward-growing stack and continues at a fixed handler address. The `sup_mode` output shows the current privilege level.

Top module: `acc_cycle_ctrl`

## Requirements
- R1: A fetch copies PC into MAR, issues one read at that address and increments PC by one during the read cycle. The returned word then passes through MBR into IR. The instruction format is opcode in bits 15:13, indirect flag in bit 12 and address in bits 11:0.
- R2: Each read strobe lasts one cycle and is followed by a cycle with no strobe, in which the data is captured. Read and write strobes are never high together, and the write data is always MBR.
- R3: When bit 12 of the instruction is 1, an extra read is issued at the address field. The word it returns (bits 11:0) becomes the effective address of the execute subcycle.
- R4: Opcode 0 (load) reads the effective address into the accumulator. It sets zero and sign from the value and clears carry and overflow.
- R5: Opcode 2 (add) adds the word at the effective address to the accumulator. It sets sign, zero, carry-out and two's-complement overflow.
- R6: Opcode 1 (store) writes the accumulator to the effective address.
- R7: Opcode 3 (jump-if-zero) loads PC with the effective address only when the zero flag is 1, and it leaves all flags unchanged.
- R8: An interrupt request is acted on only at the end of an execute subcycle while interrupt enable is 1. A request held while enable is 0 has no effect.
- R9: Interrupt entry clears interrupt enable, sets supervisor mode and decrements SP. It then writes the current PC to memory at the new SP and loads PC with HANDLER_ADDR.
- R10: Opcode 4 (return) reads memory at SP and restores PC from bits 11:0 of that word. It then increments SP, sets interrupt enable and clears supervisor mode.
- R11: Reset sets PC to RESET_PC, SP to STACK_TOP, interrupt enable to 1 and supervisor mode to 0. During reset both strobes are low.
- R12: Opcodes 5, 6 and 7 perform no operation beyond the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_addr | output | 12 | Memory address, always driven from MAR |
| mem_rd | output | 1 | Read request; data is valid one cycle later |
| mem_wr | output | 1 | Write strobe; memory stores mem_wdata at the clock edge |
| mem_wdata | output | 16 | Write data, always driven from MBR |
| mem_rdata | input | 16 | Read data, valid in the cycle after the request |
| sup_mode | output | 1 | Supervisor mode bit of the status word |

## Verification
Some properties are checked on every cycle. These are the strobe discipline and the wait cycle after each read, the PC increment in each fetch, and that interrupt entry happens only with enable set. The checker also covers the status-word and SP updates on interrupt entry and on return, and that jump-if-zero leaves the flags unchanged. Other behaviours can only be shown by the bench's program, as the exact order of bus reads and writes. These include the indirect effective-address chain, the arithmetic and flags of add (seen through a following conditional jump), the stacked return address, and a request that is ignored inside the handler.

// File: rtl/acc_cycle_pkg.sv
package acc_cycle_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 12;
  localparam int OP_W   = 3;
  localparam int IND_BIT = ADDR_W;

  localparam logic [OP_W-1:0] OP_LOAD  = 3'd0;
  localparam logic [OP_W-1:0] OP_STORE = 3'd1;
  localparam logic [OP_W-1:0] OP_ADD   = 3'd2;
  localparam logic [OP_W-1:0] OP_JZ    = 3'd3;
  localparam logic [OP_W-1:0] OP_RTI   = 3'd4;

  typedef enum logic [4:0] {
    S_F_MAR, S_F_RD, S_F_WT, S_F_IR,
    S_I_MAR, S_I_RD, S_I_WT,
    S_X_DEC, S_X_RD, S_X_WT, S_X_ALU, S_X_WR,
    S_R_RD, S_R_WT, S_R_PC,
    S_N_SAVE, S_N_MAR, S_N_WR, S_N_VEC
  } state_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic [WORD_W:0] add_wide(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic flags_t flags_of_add(input logic [WORD_W-1:0] a,
                                          input logic [WORD_W-1:0] b);
    logic [WORD_W:0] s;
    flags_t f;
    s   = add_wide(a, b);
    f.n = s[WORD_W-1];
    f.z = (s[WORD_W-1:0] == '0);
    f.c = s[WORD_W];
    f.v = (a[WORD_W-1] == b[WORD_W-1]) && (s[WORD_W-1] != a[WORD_W-1]);
    return f;
  endfunction

  function automatic flags_t flags_of_load(input logic [WORD_W-1:0] d);
    flags_t f;
    f.n = d[WORD_W-1];
    f.z = (d == '0);
    f.c = 1'b0;
    f.v = 1'b0;
    return f;
  endfunction
endpackage

// File: rtl/acc_cycle_fsm.sv
module acc_cycle_fsm
  import acc_cycle_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq,
  input  logic            ie,
  input  logic            mbr_ind,
  input  logic [OP_W-1:0] ir_op,
  output state_t          state_q,
  output logic            exec_done
);
  state_t state_d;

  always_comb begin
    exec_done = 1'b0;
    unique case (state_q)
      S_X_DEC:  exec_done = (ir_op != OP_LOAD) && (ir_op != OP_ADD) &&
                            (ir_op != OP_STORE) && (ir_op != OP_RTI);
      S_X_ALU,
      S_X_WR,
      S_R_PC:   exec_done = 1'b1;
      default:  exec_done = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (exec_done) begin
      state_d = (irq && ie) ? S_N_SAVE : S_F_MAR;
    end else begin
      unique case (state_q)
        S_F_MAR:  state_d = S_F_RD;
        S_F_RD:   state_d = S_F_WT;
        S_F_WT:   state_d = S_F_IR;
        S_F_IR:   state_d = mbr_ind ? S_I_MAR : S_X_DEC;
        S_I_MAR:  state_d = S_I_RD;
        S_I_RD:   state_d = S_I_WT;
        S_I_WT:   state_d = S_X_DEC;
        S_X_DEC: begin
          if (ir_op == OP_STORE)    state_d = S_X_WR;
          else if (ir_op == OP_RTI) state_d = S_R_RD;
          else                      state_d = S_X_RD;
        end
        S_X_RD:   state_d = S_X_WT;
        S_X_WT:   state_d = S_X_ALU;
        S_R_RD:   state_d = S_R_WT;
        S_R_WT:   state_d = S_R_PC;
        S_N_SAVE: state_d = S_N_MAR;
        S_N_MAR:  state_d = S_N_WR;
        S_N_WR:   state_d = S_N_VEC;
        S_N_VEC:  state_d = S_F_MAR;
        default:  state_d = S_F_MAR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_F_MAR;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/acc_cycle_regs.sv
module acc_cycle_regs
  import acc_cycle_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC     = '0,
  parameter logic [ADDR_W-1:0] STACK_TOP    = '1,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_t            state_q,
  input  logic              zero_flag,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] mar_q,
  output logic [WORD_W-1:0] mbr_q,
  output logic [OP_W-1:0]   ir_op_q,
  output logic [WORD_W-1:0] acc_q,
  output logic [ADDR_W-1:0] sp_q
);
  localparam int PAD_W = WORD_W - ADDR_W;

  logic [ADDR_W-1:0] ea;
  logic [WORD_W:0]   sum;
  assign ea  = mbr_q[ADDR_W-1:0];
  assign sum = add_wide(acc_q, mbr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      mar_q   <= '0;
      mbr_q   <= '0;
      ir_op_q <= '0;
      acc_q   <= '0;
      sp_q    <= STACK_TOP;
    end else begin
      unique case (state_q)
        S_F_MAR: mar_q <= pc_q;
        S_F_RD:  pc_q  <= pc_q + 1'b1;
        S_F_WT,
        S_I_WT,
        S_X_WT,
        S_R_WT:  mbr_q <= mem_rdata;
        S_F_IR:  ir_op_q <= mbr_q[WORD_W-1 -: OP_W];
        S_I_MAR: mar_q <= ea;
        S_X_DEC: begin
          unique case (ir_op_q)
            OP_LOAD, OP_ADD: mar_q <= ea;
            OP_STORE: begin
              mar_q <= ea;
              mbr_q <= acc_q;
            end
            OP_JZ:   if (zero_flag) pc_q <= ea;
            OP_RTI:  mar_q <= sp_q;
            default: ;
          endcase
        end
        S_X_ALU: acc_q <= (ir_op_q == OP_ADD) ? sum[WORD_W-1:0] : mbr_q;
        S_R_PC: begin
          pc_q <= ea;
          sp_q <= sp_q + 1'b1;
        end
        S_N_SAVE: begin
          mbr_q <= {{PAD_W{1'b0}}, pc_q};
          sp_q  <= sp_q - 1'b1;
        end
        S_N_MAR: mar_q <= sp_q;
        S_N_VEC: pc_q  <= HANDLER_ADDR;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_cycle_psw.sv
module acc_cycle_psw
  import acc_cycle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  state_t            state_q,
  input  logic [OP_W-1:0]   ir_op,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] mbr,
  output flags_t            flags_q,
  output logic              ie_q,
  output logic              sup_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ie_q    <= 1'b1;
      sup_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_X_ALU: flags_q <= (ir_op == OP_ADD) ? flags_of_add(acc, mbr)
                                              : flags_of_load(mbr);
        S_N_SAVE: begin
          ie_q  <= 1'b0;
          sup_q <= 1'b1;
        end
        S_R_PC: begin
          ie_q  <= 1'b1;
          sup_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_cycle_ctrl.sv
module acc_cycle_ctrl
  import acc_cycle_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC     = 12'h000,
  parameter logic [ADDR_W-1:0] STACK_TOP    = 12'hF00,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              sup_mode
);
  state_t            state_q;
  logic              exec_done;
  logic [ADDR_W-1:0] pc_q, mar_q, sp_q;
  logic [WORD_W-1:0] mbr_q, acc_q;
  logic [OP_W-1:0]   ir_op_q;
  flags_t            flags_q;
  logic              ie_q, sup_q;

  // named events for the checker
  logic fetch_req, int_save, rti_done, exec_jz;
  assign fetch_req = (state_q == S_F_RD);
  assign int_save  = (state_q == S_N_SAVE);
  assign rti_done  = (state_q == S_R_PC);
  assign exec_jz   = (state_q == S_X_DEC) && (ir_op_q == OP_JZ);

  acc_cycle_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ie(ie_q),
    .mbr_ind(mbr_q[IND_BIT]), .ir_op(ir_op_q),
    .state_q(state_q), .exec_done(exec_done)
  );

  acc_cycle_regs #(
    .RESET_PC(RESET_PC), .STACK_TOP(STACK_TOP), .HANDLER_ADDR(HANDLER_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .zero_flag(flags_q.z),
    .mem_rdata(mem_rdata), .pc_q(pc_q), .mar_q(mar_q), .mbr_q(mbr_q),
    .ir_op_q(ir_op_q), .acc_q(acc_q), .sp_q(sp_q)
  );

  acc_cycle_psw psw_i (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .ir_op(ir_op_q),
    .acc(acc_q), .mbr(mbr_q), .flags_q(flags_q), .ie_q(ie_q), .sup_q(sup_q)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_rd    = (state_q == S_F_RD) || (state_q == S_I_RD) ||
                     (state_q == S_X_RD) || (state_q == S_R_RD);
  assign mem_wr    = (state_q == S_X_WR) || (state_q == S_N_WR);
  assign sup_mode  = sup_q;
endmodule

// File: rtl/acc_cycle_chk.sv
module acc_cycle_chk
  import acc_cycle_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              fetch_req,
  input logic              int_save,
  input logic              rti_done,
  input logic              exec_jz,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] sp_q,
  input logic              ie_q,
  input logic              sup_q,
  input flags_t            flags_q
);
  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> pc_q == $past(pc_q) + 1'b1);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R2
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd && !mem_wr);

  // R7
  jz_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_jz |=> $stable(flags_q));

  // R8
  int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_save |-> ie_q);

  // R9
  int_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_save |=> !ie_q && sup_q && sp_q == $past(sp_q) - 1'b1);

  // R10
  rti_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rti_done |=> ie_q && !sup_q && sp_q == $past(sp_q) + 1'b1);
endmodule

bind acc_cycle_ctrl acc_cycle_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .fetch_req(fetch_req), .int_save(int_save), .rti_done(rti_done),
  .exec_jz(exec_jz), .pc_q(pc_q), .sp_q(sp_q), .ie_q(ie_q), .sup_q(sup_q),
  .flags_q(flags_q)
);

// File: tb/acc_cycle_ctrl_tb_top.sv
module acc_cycle_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        sup_mode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    logic        wr;
    logic [11:0] a;
    logic [15:0] d;
    string       req;
  } exp_t;
  exp_t expq[$];

  logic [15:0] mem [0:4095];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sup_mode(sup_mode)
  );

  // behavioural single-port memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [15:0] ins(input logic [2:0] op, input logic ind,
                                      input logic [11:0] a);
    return {op, ind, a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_rd(input logic [11:0] a, input string req);
    exp_t e;
    e.wr = 1'b0; e.a = a; e.d = '0; e.req = req;
    expq.push_back(e);
  endtask

  task automatic push_wr(input logic [11:0] a, input logic [15:0] d, input string req);
    exp_t e;
    e.wr = 1'b1; e.a = a; e.d = d; e.req = req;
    expq.push_back(e);
  endtask

  // monitor: compare bus events against the scoreboard
  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      // R11: no strobes and user mode while in reset
      check(!mem_rd && !mem_wr && !sup_mode, "R11", "reset outputs",
            {29'd0, mem_rd, mem_wr, sup_mode}, 32'd0);
    end else if ((mem_rd || mem_wr) && expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      check(mem_wr == e.wr && mem_addr == e.a, e.req, "bus kind/address",
            {19'd0, mem_wr, mem_addr}, {19'd0, e.wr, e.a});
      if (e.wr) check(mem_wdata == e.d, e.req, "write data",
                      {16'd0, mem_wdata}, {16'd0, e.d});
      check(!(mem_rd && mem_wr), "R2", "strobes exclusive",
            {30'd0, mem_rd, mem_wr}, 32'd0);
      if (!e.wr && e.a == 12'h00D) irq = 1'b1;
      if (!e.wr && e.a == 12'hEFF) irq = 1'b0;
      if (!e.wr && e.a == 12'h100)
        check(sup_mode == 1'b1, "R9", "supervisor in handler", {31'd0, sup_mode}, 32'd1);
      if (!e.wr && e.a == 12'h00E)
        check(sup_mode == 1'b0, "R10", "user mode after return", {31'd0, sup_mode}, 32'd0);
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    // program
    mem[12'h000] = ins(3'd0, 1'b0, 12'h200);  // load 5
    mem[12'h001] = ins(3'd2, 1'b0, 12'h201);  // add -5 -> 0, Z
    mem[12'h002] = ins(3'd1, 1'b0, 12'h300);  // store 0
    mem[12'h003] = ins(3'd3, 1'b0, 12'h008);  // jz taken
    mem[12'h004] = ins(3'd1, 1'b0, 12'h3FF);  // must be skipped
    mem[12'h008] = ins(3'd0, 1'b1, 12'h202);  // load indirect -> 0x1234
    mem[12'h009] = ins(3'd2, 1'b0, 12'h204);  // add 0x7000 -> 0x8234
    mem[12'h00A] = ins(3'd1, 1'b0, 12'h301);
    mem[12'h00B] = ins(3'd3, 1'b0, 12'h000);  // jz not taken
    mem[12'h00C] = ins(3'd1, 1'b1, 12'h205);  // store indirect -> 0x302
    mem[12'h00D] = ins(3'd0, 1'b0, 12'h200);  // load 5, interrupt after
    mem[12'h00E] = ins(3'd3, 1'b0, 12'h000);  // jz not taken
    mem[12'h00F] = ins(3'd7, 1'b0, 12'h3FE);  // no operation
    mem[12'h010] = ins(3'd0, 1'b0, 12'h206);  // load 0
    mem[12'h011] = ins(3'd3, 1'b0, 12'h011);  // jz self
    mem[12'h100] = ins(3'd1, 1'b0, 12'h303);  // handler: store acc
    mem[12'h101] = ins(3'd4, 1'b0, 12'h000);  // return
    mem[12'h200] = 16'h0005;
    mem[12'h201] = 16'hFFFB;
    mem[12'h202] = 16'h0203;
    mem[12'h203] = 16'h1234;
    mem[12'h204] = 16'h7000;
    mem[12'h205] = 16'h0302;
    mem[12'h206] = 16'h0000;

    push_rd(12'h000, "R1 R11 fetch at reset PC");
    push_rd(12'h200, "R4 load operand");
    push_rd(12'h001, "R1 PC incremented");
    push_rd(12'h201, "R5 add operand");
    push_rd(12'h002, "R1");
    push_wr(12'h300, 16'h0000, "R5 R6 sum of 5 and -5");
    push_rd(12'h003, "R1");
    push_rd(12'h008, "R7 jump taken on zero");
    push_rd(12'h202, "R3 indirect pointer read");
    push_rd(12'h203, "R3 R4 operand at effective address");
    push_rd(12'h009, "R1");
    push_rd(12'h204, "R5");
    push_rd(12'h00A, "R1");
    push_wr(12'h301, 16'h8234, "R5 R6 add result");
    push_rd(12'h00B, "R1");
    push_rd(12'h00C, "R7 jump not taken when zero clear");
    push_rd(12'h205, "R3 indirect store pointer");
    push_wr(12'h302, 16'h8234, "R3 R6 indirect store");
    push_rd(12'h00D, "R1");
    push_rd(12'h200, "R4");
    push_wr(12'hEFF, 16'h000E, "R8 R9 push return PC at SP-1");
    push_rd(12'h100, "R9 handler fetch");
    push_wr(12'h303, 16'h0005, "R6 handler store");
    push_rd(12'h101, "R8 request ignored while disabled");
    push_rd(12'hEFF, "R10 pop at SP");
    push_rd(12'h00E, "R10 PC restored");
    push_rd(12'h00F, "R7 load 5 left zero clear");
    push_rd(12'h010, "R12 no-op does no access");
    push_rd(12'h206, "R4");
    push_rd(12'h011, "R1");
    push_rd(12'h011, "R4 R7 zero from load, jump to self");

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    wait (rst_n == 1'b1);
    while (expq.size() > 0 && cycles < WATCHDOG) @(posedge clk);
    if (expq.size() > 0) begin
      fails++;
      $display("FAIL watchdog: %0d bus events still expected", expq.size());
    end
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule